// File: doc/BRIEF.md
# Oversampling Strobe Prescaler with Phase Trim

This block produces the oversampling strobe for a sigma-delta modem datapath. A fast reference clock is divided by a programmable prescale value plus one. The result is a one-cycle strobe that paces the transmit and receive sample streams. The strobe runs whenever either direction is enabled.

The receive sampling phase can be moved without changing the average rate. Software loads a small step count and a direction into a phase-trim register. While receive is enabled, the block then shortens (advance) or lengthens (delay) one divider period per step by a single reference clock. The count drains itself: it decrements once per adjusted period. The remaining count can be read back at any time.

The phase-trim register may only be reloaded while no adjustment is in progress. A reload that arrives too early is dropped and latches a reject flag.

Top module: `osr_strobe_gen`

## Requirements
- R1: After reset, the control register holds prescale 5'b01001 with both enables at 0, the phase-trim register reads 0, `ft_reject` is 0 and `osr_strobe` is 0.
- R2: While transmit or receive is enabled and no trim step is pending, `osr_strobe` pulses high for exactly one clock once every prescale+1 clocks.
- R3: A control write that enables the block from the disabled state, with prescale P, produces the first strobe P+2 clock edges after the write edge.
- R4: From the second clock edge after a write that clears both enables, `osr_strobe` stays low. The divider restarts from zero on the next enable, as in R3.
- R5: A prescale value written while the divider runs does not alter the current period. It sets the length of the periods that follow.
- R6: An advance step (direction bit 1) shortens one divider period by one clock. Only one step is applied per period, and steps are applied only while receive is enabled.
- R7: A delay step (direction bit 0) lengthens one divider period by one clock. Only one step is applied per period.
- R8: The step field, read on `steps_left` and in phase-trim readback bits 2:0, decrements by one at the end of each adjusted period and stops at 0.
- R9: A phase-trim write that arrives while receive is enabled and the step count is nonzero is ignored, leaving count and direction unchanged, and sets `ft_reject`. The flag stays set until a phase-trim write is accepted.
- R10: While receive is disabled, pending steps are frozen, periods keep their normal length, and every phase-trim write is accepted.
- R11: Register select 0 is control, with prescale in bits 4:0, receive enable in bit 8 and transmit enable in bit 9. Register select 1 is phase trim, with step count in bits 2:0 and direction in bit 3. All other readback bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 phase trim |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Readback select: 0 control, 1 phase trim |
| rd_data | output | 16 | Combinational readback of the selected register |
| osr_strobe | output | 1 | One-clock oversampling strobe |
| steps_left | output | 3 | Trim steps not yet applied |
| ft_reject | output | 1 | Sticky flag for a dropped phase-trim write |

## Verification
The properties assume that `wr_sel` selects one register per cycle and that a phase-trim reload is the only event, apart from a period end, that can change the step count. Every count property is therefore gated on the absence of a phase-trim write in the sampled cycle.

The stimulus drives each write for exactly one clock and keeps the other inputs stable otherwise. It issues trim writes on the clock after an observed strobe. This lands each adjustment early in a period, so the adjusted limit is never below the count already reached.

// File: rtl/osr_pkg.sv
package osr_pkg;
   // control register field positions shared by write decode and readback
   localparam int unsigned CTL_RX_BIT = 8;
   localparam int unsigned CTL_TX_BIT = 9;
   localparam int unsigned CTL_TOP_BIT = 9;

   typedef enum logic {
      TRIM_DELAY   = 1'b0,
      TRIM_ADVANCE = 1'b1
   } trim_dir_e;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_TRIM = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/osr_ctl_reg.sv
module osr_ctl_reg
   import osr_pkg::*;
#(
   parameter int unsigned PRES_W   = 5,
   parameter int unsigned PRES_RST = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctl,
   input  logic [PRES_W-1:0] wr_pres,
   input  logic              wr_rx,
   input  logic              wr_tx,
   output logic [PRES_W-1:0] pres,
   output logic              rx_en,
   output logic              tx_en
);
   localparam logic [PRES_W-1:0] PRES_INIT = PRES_W'(PRES_RST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pres  <= PRES_INIT;
         rx_en <= 1'b0;
         tx_en <= 1'b0;
      end else if (wr_ctl) begin
         pres  <= wr_pres;
         rx_en <= wr_rx;
         tx_en <= wr_tx;
      end
   end
endmodule

// File: rtl/osr_step_ctl.sv
module osr_step_ctl
   import osr_pkg::*;
#(
   parameter int unsigned STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_trim,
   input  logic [STEP_W-1:0] wr_steps,
   input  trim_dir_e         wr_dir,
   input  logic              rx_en,
   input  logic              period_end,
   output logic [STEP_W-1:0] steps_left,
   output trim_dir_e         step_dir,
   output logic              step_pending,
   output logic              reject
);
   localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);

   logic busy;
   logic accept;

   // an adjustment is in flight only while receive timing is live
   assign busy         = rx_en && (steps_left != '0);
   assign accept       = wr_trim && !busy;
   assign step_pending = busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         steps_left <= '0;
         step_dir   <= TRIM_DELAY;
      end else if (accept) begin
         steps_left <= wr_steps;
         step_dir   <= wr_dir;
      end else if (busy && period_end) begin
         steps_left <= steps_left - STEP_ONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reject <= 1'b0;
      end else if (wr_trim) begin
         reject <= busy;
      end
   end
endmodule

// File: rtl/osr_divider.sv
module osr_divider
   import osr_pkg::*;
#(
   parameter int unsigned PRES_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [PRES_W-1:0] pres,
   input  logic              step_pending,
   input  trim_dir_e         step_dir,
   output logic              period_end,
   output logic              osr_strobe
);
   localparam int unsigned CNT_W = PRES_W + 1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic              run_q;
   logic              go;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  limit;
   logic [PRES_W-1:0] pres_q;

   // first enabled cycle only arms the divider and latches the prescale
   assign go = run_q && active;

   always_comb begin
      limit = {1'b0, pres_q};
      if (step_pending) begin
         if (step_dir == TRIM_ADVANCE) begin
            if (pres_q != '0) limit = limit - CNT_ONE;
         end else begin
            limit = limit + CNT_ONE;
         end
      end
   end

   // >= keeps a limit that drops mid-period from being overrun
   assign period_end = go && (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q      <= 1'b0;
         cnt_q      <= '0;
         pres_q     <= '0;
         osr_strobe <= 1'b0;
      end else begin
         run_q      <= active;
         osr_strobe <= period_end;
         if (!go || period_end) begin
            cnt_q  <= '0;
            pres_q <= pres;
         end else begin
            cnt_q  <= cnt_q + CNT_ONE;
         end
      end
   end
endmodule

// File: rtl/osr_strobe_gen.sv
module osr_strobe_gen
   import osr_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned PRES_W   = 5,
   parameter int unsigned STEP_W   = 3,
   parameter int unsigned PRES_RST = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              osr_strobe,
   output logic [STEP_W-1:0] steps_left,
   output logic              ft_reject
);
   localparam int unsigned DIR_BIT = STEP_W;

   if (PRES_W < 2 || PRES_W > CTL_RX_BIT) begin : g_bad_pres
      $error("PRES_W must lie between 2 and the receive-enable bit position");
   end
   if (DATA_W <= CTL_TOP_BIT || DATA_W <= DIR_BIT) begin : g_bad_data
      $error("DATA_W too narrow for the register fields");
   end
   if (PRES_RST >= (1 << PRES_W)) begin : g_bad_rst
      $error("PRES_RST does not fit in PRES_W bits");
   end

   logic [PRES_W-1:0] pres;
   logic              rx_en;
   logic              tx_en;
   logic              period_end;
   logic              step_pending;
   trim_dir_e         step_dir;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data;

   osr_ctl_reg #(
      .PRES_W   (PRES_W),
      .PRES_RST (PRES_RST)
   ) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (wr_en && (wr_sel == SEL_CTRL)),
      .wr_pres (wr_data[PRES_W-1:0]),
      .wr_rx   (wr_data[CTL_RX_BIT]),
      .wr_tx   (wr_data[CTL_TX_BIT]),
      .pres    (pres),
      .rx_en   (rx_en),
      .tx_en   (tx_en)
   );

   osr_step_ctl #(
      .STEP_W (STEP_W)
   ) u_step (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_trim      (wr_en && (wr_sel == SEL_TRIM)),
      .wr_steps     (wr_data[STEP_W-1:0]),
      .wr_dir       (trim_dir_e'(wr_data[DIR_BIT])),
      .rx_en        (rx_en),
      .period_end   (period_end),
      .steps_left   (steps_left),
      .step_dir     (step_dir),
      .step_pending (step_pending),
      .reject       (ft_reject)
   );

   osr_divider #(
      .PRES_W (PRES_W)
   ) u_div (
      .clk          (clk),
      .rst_n        (rst_n),
      .active       (tx_en || rx_en),
      .pres         (pres),
      .step_pending (step_pending),
      .step_dir     (step_dir),
      .period_end   (period_end),
      .osr_strobe   (osr_strobe)
   );

   always_comb begin
      rd_data = '0;
      if (rd_sel == SEL_TRIM) begin
         rd_data[STEP_W-1:0] = steps_left;
         rd_data[DIR_BIT]    = step_dir;
      end else begin
         rd_data[PRES_W-1:0] = pres;
         rd_data[CTL_RX_BIT] = rx_en;
         rd_data[CTL_TX_BIT] = tx_en;
      end
   end
endmodule

// File: rtl/osr_strobe_gen_chk.sv
module osr_strobe_gen_chk #(
   parameter int unsigned STEP_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic              osr_strobe,
   input logic              tx_en,
   input logic              rx_en,
   input logic [STEP_W-1:0] steps_left,
   input logic              ft_reject
);
   localparam logic [STEP_W-1:0] ONE = STEP_W'(1);

   // R2: a strobe only follows a cycle with some direction enabled
   a_r2_strobe_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      osr_strobe |-> $past(tx_en || rx_en));

   // R4: disabled state yields no strobe on the following cycle
   a_r4_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_en || rx_en) |=> !osr_strobe);

   // R8: outside a trim write the count holds or drops by exactly one
   a_r8_single_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en && wr_sel) |->
         (steps_left == $past(steps_left)) || (steps_left == $past(steps_left) - ONE));

   // R9: a trim write during an active adjustment is dropped and flagged
   a_r9_reject_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel && rx_en && (steps_left != '0)) |=>
         ft_reject && ((steps_left == $past(steps_left)) ||
                       (steps_left == $past(steps_left) - ONE)));

   // R10: without receive and without a trim write the count is frozen
   a_r10_steps_frozen_without_rx: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !(wr_en && wr_sel)) |=> $stable(steps_left));
endmodule

bind osr_strobe_gen osr_strobe_gen_chk #(.STEP_W(STEP_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .osr_strobe (osr_strobe),
   .tx_en      (tx_en),
   .rx_en      (rx_en),
   .steps_left (steps_left),
   .ft_reject  (ft_reject)
);

// File: tb/test_osr_strobe_gen.sv
module test_osr_strobe_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic        rd_sel = 1'b0;
   logic [15:0] rd_data;
   logic        osr_strobe;
   logic [2:0]  steps_left;
   logic        ft_reject;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   osr_strobe_gen i_osr_strobe_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .rd_sel     (rd_sel),
      .rd_data    (rd_data),
      .osr_strobe (osr_strobe),
      .steps_left (steps_left),
      .ft_reject  (ft_reject)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wr_en = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic write_reg(bit sel, logic [15:0] data);
      wr_sel  = sel;
      wr_data = data;
      wr_en   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic read_reg(bit sel, output int val);
      rd_sel = sel;
      #1;
      val = int'(rd_data);
   endtask

   task automatic sync_strobe();
      for (int i = 0; i < 300; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (osr_strobe) return;
      end
   endtask

   task automatic measure(output int n);
      n = 0;
      for (int i = 0; i < 300; i++) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (osr_strobe) return;
      end
      n = -1;
   endtask

   task automatic t_reset_state();
      int v;
      do_reset();
      read_reg(1'b0, v);
      chk("R1", "control after reset", v, 'h0009);
      read_reg(1'b1, v);
      chk("R1", "trim after reset", v, 0);
      chk("R1", "reject after reset", int'(ft_reject), 0);
      chk("R1", "strobe after reset", int'(osr_strobe), 0);
      chk("R1", "steps after reset", int'(steps_left), 0);
   endtask

   task automatic t_rate_and_start();
      int n;
      write_reg(1'b0, 16'h0209);
      measure(n);
      chk("R3", "first strobe delay P=9", n, 11);
      measure(n);
      chk("R2", "period P=9", n, 10);
      @(posedge clk);
      @(negedge clk);
      chk("R2", "pulse one clock wide", int'(osr_strobe), 0);
      measure(n);
      chk("R2", "period after width check", n, 9);
   endtask

   task automatic t_prescale_change();
      int n;
      sync_strobe();
      write_reg(1'b0, 16'h0204);
      measure(n);
      chk("R5", "current period keeps old prescale", n, 9);
      measure(n);
      chk("R5", "new prescale period", n, 5);
      measure(n);
      chk("R5", "new prescale period again", n, 5);
   endtask

   task automatic t_disable();
      int n;
      int seen;
      write_reg(1'b0, 16'h0004);
      @(posedge clk);
      @(negedge clk);
      seen = 0;
      for (int i = 0; i < 40; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (osr_strobe) seen++;
      end
      chk("R4", "strobes while disabled", seen, 0);
      write_reg(1'b0, 16'h0204);
      measure(n);
      chk("R4", "restart first strobe P=4 (R3)", n, 6);
      write_reg(1'b0, 16'h0000);
   endtask

   task automatic t_advance();
      int n;
      do_reset();
      write_reg(1'b0, 16'h0109);
      sync_strobe();
      write_reg(1'b1, 16'h000B);
      chk("R8", "steps loaded", int'(steps_left), 3);
      measure(n);
      chk("R6", "advanced period 1", n, 8);
      chk("R8", "steps after period 1", int'(steps_left), 2);
      measure(n);
      chk("R6", "advanced period 2", n, 9);
      chk("R8", "steps after period 2", int'(steps_left), 1);
      measure(n);
      chk("R6", "advanced period 3", n, 9);
      chk("R8", "steps after period 3", int'(steps_left), 0);
      measure(n);
      chk("R6", "normal period after drain", n, 10);
      chk("R8", "steps stay at zero", int'(steps_left), 0);
   endtask

   task automatic t_delay();
      int n;
      int v;
      sync_strobe();
      write_reg(1'b1, 16'h0002);
      measure(n);
      chk("R7", "delayed period 1", n, 10);
      measure(n);
      chk("R7", "delayed period 2", n, 11);
      measure(n);
      chk("R7", "normal period after delay", n, 10);
      read_reg(1'b1, v);
      chk("R8", "trim readback after delay drain", v, 0);
   endtask

   task automatic t_reject();
      int n;
      int v;
      sync_strobe();
      write_reg(1'b1, 16'h000B);
      write_reg(1'b1, 16'h0005);
      chk("R9", "reject flag set", int'(ft_reject), 1);
      chk("R9", "count unchanged by rejected write", int'(steps_left), 3);
      read_reg(1'b1, v);
      chk("R9", "trim readback unchanged", v, 'h000B);
      measure(n);
      chk("R9", "original advance still applied", n, 7);
      measure(n);
      measure(n);
      chk("R9", "steps drained", int'(steps_left), 0);
      chk("R9", "reject flag sticky", int'(ft_reject), 1);
      write_reg(1'b1, 16'h0000);
      chk("R9", "reject cleared by accepted write", int'(ft_reject), 0);
      write_reg(1'b0, 16'h0000);
   endtask

   task automatic t_no_rx();
      int n;
      int v;
      do_reset();
      write_reg(1'b0, 16'h0209);
      write_reg(1'b1, 16'h000A);
      chk("R10", "trim write accepted with receive off", int'(steps_left), 2);
      sync_strobe();
      measure(n);
      chk("R10", "period unadjusted without receive", n, 10);
      measure(n);
      chk("R10", "period unadjusted again", n, 10);
      chk("R10", "steps frozen without receive", int'(steps_left), 2);
      write_reg(1'b1, 16'h0001);
      chk("R10", "reload with pending steps accepted", int'(steps_left), 1);
      chk("R10", "no reject with receive off", int'(ft_reject), 0);
      read_reg(1'b1, v);
      chk("R10", "trim readback after reload", v, 'h0001);
      write_reg(1'b0, 16'h0000);
   endtask

   task automatic t_layout();
      int v;
      do_reset();
      write_reg(1'b0, 16'hFFFF);
      read_reg(1'b0, v);
      chk("R11", "control readback of all-ones", v, 'h031F);
      write_reg(1'b1, 16'hFFFF);
      read_reg(1'b1, v);
      chk("R11", "trim readback of all-ones", v, 'h000F);
      write_reg(1'b0, 16'h0000);
   endtask

   initial begin
      t_reset_state();
      t_rate_and_start();
      t_prescale_change();
      t_disable();
      t_advance();
      t_delay();
      t_reject();
      t_no_rx();
      t_layout();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule